// File: doc/BRIEF.md
# PHY Register Access Handshake Sequencer

This block reads and writes 16-bit registers that sit inside a PHY. The PHY cannot be reached through a memory map. The only path is a 20-bit control word that the block drives and a 17-bit status word that the PHY returns. Each step of an access is paced by one acknowledge bit in the status word. Every phase is a complete four-phase exchange: raise a strobe, see the acknowledge rise, drop the strobe, see the acknowledge fall.

A client issues one request at a time. A request carries a direction, a 16-bit register address and, for a write, 16-bit data. The block first latches the address into the PHY. For a write it then latches the data and fires a write strobe. For a read it fires a read strobe and takes the returned data from the status word. The outcome is one cycle of `done`, or one cycle of `timeout` if the acknowledge never reaches the level being waited for. The interval between acknowledge samples is a clock-cycle parameter. The default value gives about 1 µs at 250 MHz, and a bench can shorten it.

Top module: `phy_reg_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `phy_ctrl` is zero, `busy`, `done` and `timeout` are low, and `rdata` is zero.
- R2: Control word fields are as follows. Bits [15:0] carry the address or data. Bit 16 is capture-address, bit 17 is capture-data, bit 18 is write strobe and bit 19 is read strobe. At most one of bits 19:16 is set in any cycle. In the status word, bits [15:0] are read data and bit 16 is the acknowledge.
- R3: In the first cycle after a request is accepted, `phy_ctrl` carries the address with bits 19:16 clear. In the next cycle the address is carried with bit 16 set. After the acknowledge rises, the address is held with bit 16 clear until the acknowledge falls.
- R4: A write continues after the address phase in two steps. First, the data is driven alone for one cycle, then with bit 17 set; the block waits for the acknowledge to rise, then drops bit 17 and waits for it to fall. Second, bit 18 is driven alone; the block waits for the acknowledge to rise, then drives the data alone and waits for it to fall. `phy_ctrl` then returns to zero with a `done` pulse, and the PHY register holds the data.
- R5: A read continues after the address phase with bit 19 alone. The block waits for the acknowledge to rise, stores status bits [15:0] into `rdata`, drives `phy_ctrl` to zero, waits for the acknowledge to fall, then pulses `done`.
- R6: Each wait samples the acknowledge at its first cycle and then every `POLL_GAP` cycles, at most `MAX_POLLS` times. A level first seen at the last sample still counts as success. A wait whose level first appears after L cycles therefore lasts ceil(L/POLL_GAP)*POLL_GAP+1 cycles.
- R7: If no sample of a wait sees the expected level, the block pulses `timeout` instead of `done` with `phy_ctrl` at zero, and then returns to idle. A timeout in the address phase leaves the PHY register untouched.
- R8: A request is accepted only when the block is idle. `req_valid` asserted while busy, including the cycle of the `done` pulse, starts nothing and does not alter the operation in progress.
- R9: `busy` is high from the cycle after acceptance through the `done` or `timeout` cycle, and low in the cycle after. Each pulse lasts exactly one cycle, and the two never occur together.
- R10: `rdata` changes only when a read strobe is acknowledged. Writes and timed-out operations leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout | output | 1 | One-cycle pulse on an acknowledge timeout |
| rdata | output | 16 | Data from the last acknowledged read |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY |

## Verification
Two events can fall in the same cycle: the completion pulse and a new request. The bench holds `req_valid` high, with a different address, data and direction, for the whole of a write, including its `done` cycle. It then checks that `busy` stays low afterwards. It also checks that the intended register got the intended data and that the decoy address still holds its initial value. A second coincidence is an acknowledge that first appears exactly on the final poll. The bench sets the PHY model's latency to `(MAX_POLLS-1)*POLL_GAP` and then to one cycle more, and judges the outcome by the pulse kind and the exact busy length.

// File: rtl/physeq_pkg.sv
// Shared definitions for the PHY register access sequencer.
// Assumes a 16-bit PHY register space; the control/status field positions
// follow from the data width because the PHY decodes them there.
package physeq_pkg;

    localparam int DATA_W       = 16;
    localparam int CAP_ADDR_BIT = DATA_W;
    localparam int CAP_DATA_BIT = DATA_W + 1;
    localparam int WR_BIT       = DATA_W + 2;
    localparam int RD_BIT       = DATA_W + 3;
    localparam int CTRL_W       = DATA_W + 4;
    localparam int ACK_BIT      = DATA_W;
    localparam int STAT_W       = DATA_W + 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_SETUP,
        ST_ADDR_CAP,
        ST_ADDR_REL,
        ST_DATA_SETUP,
        ST_DATA_CAP,
        ST_DATA_REL,
        ST_WR_STB,
        ST_WR_REL,
        ST_RD_STB,
        ST_RD_REL,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    typedef struct packed {
        logic              is_write;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } seq_req_t;

    // True for states that poll the acknowledge bit.
    function automatic logic is_wait_state(seq_state_e s);
        return (s == ST_ADDR_CAP) || (s == ST_ADDR_REL) ||
               (s == ST_DATA_CAP) || (s == ST_DATA_REL) ||
               (s == ST_WR_STB)   || (s == ST_WR_REL)   ||
               (s == ST_RD_STB)   || (s == ST_RD_REL);
    endfunction

    // Acknowledge level awaited in a wait state: high after a strobe, low after release.
    function automatic logic wait_level(seq_state_e s);
        return (s == ST_ADDR_CAP) || (s == ST_DATA_CAP) ||
               (s == ST_WR_STB)   || (s == ST_RD_STB);
    endfunction

endpackage

// File: rtl/physeq_poll_timer.sv
// Poll pacing for one acknowledge wait.
// Produces a sample strobe on the first cycle of a wait and then every
// POLL_GAP cycles, and flags when the current sample is the last allowed.
// Assumes the sequencer pulses restart_i whenever it changes state.
module physeq_poll_timer #(
    parameter int POLL_GAP  = 250,
    parameter int MAX_POLLS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic active_i,
    output logic sample_o,
    output logic last_o
);
    localparam int GAP_W = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
    localparam int CNT_W = $clog2(MAX_POLLS + 1);
    localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(POLL_GAP - 1);
    localparam logic [CNT_W-1:0] LAST_POLL  = CNT_W'(MAX_POLLS - 1);

    logic [GAP_W-1:0] gap_q;
    logic [CNT_W-1:0] polls_q;

    // Gap down-counter and sample counter, cleared at every wait entry.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            gap_q   <= '0;
            polls_q <= '0;
        end else if (active_i) begin
            if (gap_q == '0) begin
                gap_q <= GAP_RELOAD;
                if (polls_q != LAST_POLL) begin
                    polls_q <= polls_q + 1'b1;
                end
            end else begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    assign sample_o = active_i && (gap_q == '0);
    assign last_o   = (polls_q == LAST_POLL);

endmodule

// File: rtl/physeq_ctrl_fsm.sv
// Handshake state machine of the sequencer.
// Walks the address phase, then either the data and write-strobe phases or
// the read-strobe phase, and decodes the PHY control word from its state.
// Assumes ack_i is already synchronous to clk.
module physeq_ctrl_fsm
    import physeq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [DATA_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              ack_i,
    input  logic              sample_i,
    input  logic              last_i,
    output logic              restart_o,
    output logic              in_wait_o,
    output logic              rd_capture_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o
);
    seq_state_e state_q, state_d;
    seq_req_t   req_q;
    logic       hit;
    logic       give_up;

    // Sample outcome for the current wait.
    always_comb begin
        hit     = sample_i && (ack_i == wait_level(state_q));
        give_up = sample_i && (ack_i != wait_level(state_q)) && last_i;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid_i) state_d = ST_ADDR_SETUP;
            ST_ADDR_SETUP: state_d = ST_ADDR_CAP;
            ST_DATA_SETUP: state_d = ST_DATA_CAP;
            ST_ADDR_CAP:   if (hit) state_d = ST_ADDR_REL;
                           else if (give_up) state_d = ST_FAIL;
            ST_ADDR_REL:   if (hit) state_d = req_q.is_write ? ST_DATA_SETUP : ST_RD_STB;
                           else if (give_up) state_d = ST_FAIL;
            ST_DATA_CAP:   if (hit) state_d = ST_DATA_REL;
                           else if (give_up) state_d = ST_FAIL;
            ST_DATA_REL:   if (hit) state_d = ST_WR_STB;
                           else if (give_up) state_d = ST_FAIL;
            ST_WR_STB:     if (hit) state_d = ST_WR_REL;
                           else if (give_up) state_d = ST_FAIL;
            ST_WR_REL:     if (hit) state_d = ST_DONE;
                           else if (give_up) state_d = ST_FAIL;
            ST_RD_STB:     if (hit) state_d = ST_RD_REL;
                           else if (give_up) state_d = ST_FAIL;
            ST_RD_REL:     if (hit) state_d = ST_DONE;
                           else if (give_up) state_d = ST_FAIL;
            ST_DONE:       state_d = ST_IDLE;
            ST_FAIL:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request latch, loaded only on acceptance in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if ((state_q == ST_IDLE) && req_valid_i) begin
            req_q.is_write <= req_write_i;
            req_q.addr     <= req_addr_i;
            req_q.wdata    <= req_wdata_i;
        end
    end

    // Control word decode per state.
    always_comb begin
        ctrl_o = '0;
        unique case (state_q)
            ST_ADDR_SETUP, ST_ADDR_REL: ctrl_o[DATA_W-1:0] = req_q.addr;
            ST_ADDR_CAP: begin
                ctrl_o[DATA_W-1:0]   = req_q.addr;
                ctrl_o[CAP_ADDR_BIT] = 1'b1;
            end
            ST_DATA_SETUP, ST_DATA_REL, ST_WR_REL: ctrl_o[DATA_W-1:0] = req_q.wdata;
            ST_DATA_CAP: begin
                ctrl_o[DATA_W-1:0]   = req_q.wdata;
                ctrl_o[CAP_DATA_BIT] = 1'b1;
            end
            ST_WR_STB: ctrl_o[WR_BIT] = 1'b1;
            ST_RD_STB: ctrl_o[RD_BIT] = 1'b1;
            default:   ctrl_o = '0;
        endcase
    end

    // Status and timer handshake outputs.
    always_comb begin
        restart_o    = (state_d != state_q);
        in_wait_o    = is_wait_state(state_q);
        rd_capture_o = (state_q == ST_RD_STB) && hit;
        busy_o       = (state_q != ST_IDLE);
        done_o       = (state_q == ST_DONE);
        timeout_o    = (state_q == ST_FAIL);
    end

endmodule

// File: rtl/physeq_rdata_cap.sv
// Read data holding register.
// Loads the status data field when the sequencer flags an acknowledged
// read strobe and holds it otherwise.
module physeq_rdata_cap
    import physeq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] stat_data_i,
    output logic [DATA_W-1:0] rdata_o
);
    // Capture register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (capture_i) begin
            rdata_o <= stat_data_i;
        end
    end

endmodule

// File: rtl/phy_reg_sequencer.sv
// Top level of the PHY register access sequencer.
// Accepts one read or write at a time and runs the four-phase acknowledge
// handshakes against the PHY control and status words.
// Assumes phy_stat is synchronous to clk.
module phy_reg_sequencer
    import physeq_pkg::*;
#(
    parameter int POLL_GAP  = 250,
    parameter int MAX_POLLS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [DATA_W-1:0] rdata,
    output logic [CTRL_W-1:0] phy_ctrl,
    input  logic [STAT_W-1:0] phy_stat
);
    logic restart;
    logic in_wait;
    logic sample;
    logic last;
    logic rd_capture;

    physeq_poll_timer #(
        .POLL_GAP  (POLL_GAP),
        .MAX_POLLS (MAX_POLLS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .active_i  (in_wait),
        .sample_o  (sample),
        .last_o    (last)
    );

    physeq_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_write_i  (req_write),
        .req_addr_i   (req_addr),
        .req_wdata_i  (req_wdata),
        .ack_i        (phy_stat[ACK_BIT]),
        .sample_i     (sample),
        .last_i       (last),
        .restart_o    (restart),
        .in_wait_o    (in_wait),
        .rd_capture_o (rd_capture),
        .ctrl_o       (phy_ctrl),
        .busy_o       (busy),
        .done_o       (done),
        .timeout_o    (timeout)
    );

    physeq_rdata_cap u_rdata (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture_i   (rd_capture),
        .stat_data_i (phy_stat[DATA_W-1:0]),
        .rdata_o     (rdata)
    );

endmodule

// File: rtl/phy_reg_sequencer_chk.sv
// Property checker for the PHY register access sequencer, bound to the top.
// Observes ports only.
module phy_reg_sequencer_chk
    import physeq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              timeout,
    input logic [DATA_W-1:0] rdata,
    input logic [CTRL_W-1:0] phy_ctrl
);
    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phy_ctrl[RD_BIT:CAP_ADDR_BIT]));

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_ctrl[CAP_ADDR_BIT] && $past(phy_ctrl[CAP_ADDR_BIT])) |-> $stable(phy_ctrl[DATA_W-1:0]));

    assert_timeout_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (phy_ctrl == '0));

    assert_accept_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (phy_ctrl == '0 && !done && !timeout));

    assert_end_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));

    assert_end_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout) |=> !busy);

    assert_rdata_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> $past(phy_ctrl[RD_BIT]));

endmodule

bind phy_reg_sequencer phy_reg_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout),
    .rdata     (rdata),
    .phy_ctrl  (phy_ctrl)
);

// File: tb/phy_reg_sequencer_tb_top.sv
// Scoreboard bench for the PHY register access sequencer with a PHY model.
module phy_reg_sequencer_tb_top;
    localparam int GAP   = 4;
    localparam int POLLS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, timeout;
    logic [15:0] rdata;
    logic [19:0] phy_ctrl;
    logic [16:0] phy_stat;

    int nvec  = 0;
    int nfail = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    phy_reg_sequencer #(.POLL_GAP(GAP), .MAX_POLLS(POLLS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .timeout(timeout), .rdata(rdata), .phy_ctrl(phy_ctrl), .phy_stat(phy_stat));

    // ---------------- PHY model ----------------
    int          lat  = 2;   // cycles from strobe change to ack change
    int          mode = 0;   // 0 normal, 1 ack stuck low, 2 ack stuck high
    logic        ack;
    int          hi_cnt, lo_cnt;
    logic [15:0] mdl_addr, mdl_data, mdl_rd;
    logic [15:0] phy_mem [16];
    logic [15:0] exp_mem [16];

    function automatic logic [15:0] init_val(int i);
        return 16'h5A3C ^ 16'(i * 16'h0111);
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) begin
            phy_mem[i] = init_val(i);
            exp_mem[i] = init_val(i);
        end
    end

    assign phy_stat = {ack, mdl_rd};

    always @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0; hi_cnt <= 0; lo_cnt <= 0; mdl_rd <= '0;
            mdl_addr <= '0; mdl_data <= '0;
        end else begin
            if (phy_ctrl[16]) mdl_addr <= phy_ctrl[15:0];
            if (phy_ctrl[17]) mdl_data <= phy_ctrl[15:0];
            if (phy_ctrl[18]) phy_mem[mdl_addr[3:0]] <= mdl_data;
            if (phy_ctrl[19]) mdl_rd <= phy_mem[mdl_addr[3:0]];
            if (mode == 1) ack <= 1'b0;
            else if (mode == 2) ack <= 1'b1;
            else if (|phy_ctrl[19:16]) begin
                lo_cnt <= 0; hi_cnt <= hi_cnt + 1;
                if (hi_cnt + 1 >= lat) ack <= 1'b1;
            end else begin
                hi_cnt <= 0; lo_cnt <= lo_cnt + 1;
                if (lo_cnt + 1 >= lat) ack <= 1'b0;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        bit          is_to;
        bit          chk_rd;
        logic [15:0] rd;
        string       tag;
    } exp_t;
    exp_t sb[$];

    // Monitor: pops an expected item at every completion pulse.
    always @(negedge clk) begin
        if (rst_n && (done || timeout)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9", "unexpected completion", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(timeout == e.is_to, e.tag, "timeout vs done", timeout, e.is_to);
                check(phy_ctrl == '0, "R7", "ctrl zero at completion", phy_ctrl, 0);
                if (e.chk_rd) check(rdata == e.rd, "R5", "read data", rdata, e.rd);
            end
        end
    end

    function automatic int wait_len(int l);
        return ((l + GAP - 1) / GAP) * GAP + 1;
    endfunction

    // Driver: issues one op, pushes the expectation, measures busy length.
    task automatic run_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          input bit exp_to, input int exp_busy, input bit inject,
                          input string tag);
        exp_t e;
        int   bc;
        int   guard;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        e.is_to = exp_to; e.chk_rd = !wr && !exp_to; e.rd = exp_mem[a[3:0]]; e.tag = tag;
        sb.push_back(e);
        if (wr && !exp_to) exp_mem[a[3:0]] = d;
        @(negedge clk);
        if (inject) begin
            req_write = ~wr; req_addr = a ^ 16'h0009; req_wdata = ~d;
        end else begin
            req_valid = 1'b0;
        end
        check(phy_ctrl == 20'(a), "R3", "address alone", phy_ctrl, 20'(a));
        bc = 1;
        @(negedge clk);
        check(phy_ctrl == (20'(a) | 20'h10000), "R3", "address with capture", phy_ctrl,
              20'(a) | 20'h10000);
        bc = 2;
        guard = 0;
        @(negedge clk);
        while (busy && guard < 5000) begin
            bc++; guard++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (exp_busy >= 0) check(bc == exp_busy, exp_to ? "R7" : "R6", "busy length", bc, exp_busy);
        check(!done && !timeout, "R9", "pulse single cycle", {done, timeout}, 0);
        @(negedge clk);
        check(!busy, inject ? "R8" : "R9", "stays idle after completion", busy, 0);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            nvec++; nfail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] last_rd;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(phy_ctrl == '0, "R1", "ctrl after reset", phy_ctrl, 0);
        check(!busy && !done && !timeout, "R1", "flags after reset", {busy, done, timeout}, 0);
        check(rdata == '0, "R1", "rdata after reset", rdata, 0);

        // Normal accesses, latency 2.
        lat = 2;
        run_op(1'b1, 16'h0003, 16'h1234, 1'b0, 3 + 6 * wait_len(2), 1'b0, "R4");
        check(phy_mem[3] == 16'h1234, "R4", "PHY register written", phy_mem[3], 16'h1234);
        run_op(1'b0, 16'h0003, 16'h0000, 1'b0, 2 + 4 * wait_len(2), 1'b0, "R5");
        run_op(1'b0, 16'h0005, 16'h0000, 1'b0, -1, 1'b0, "R5");
        last_rd = init_val(5);
        run_op(1'b1, 16'h0006, 16'hBEEF, 1'b0, -1, 1'b0, "R4");
        check(rdata == last_rd, "R10", "rdata kept over write", rdata, last_rd);
        run_op(1'b0, 16'h0006, 16'h0000, 1'b0, -1, 1'b0, "R5");
        last_rd = 16'hBEEF;

        // Acknowledge first seen on the last poll.
        lat = (POLLS - 1) * GAP;
        run_op(1'b0, 16'h0003, 16'h0000, 1'b0, 2 + 4 * wait_len(lat), 1'b0, "R6");
        last_rd = 16'h1234;
        run_op(1'b1, 16'h0004, 16'h0F0F, 1'b0, 3 + 6 * wait_len(lat), 1'b0, "R6");

        // One cycle too late: timeout.
        lat = (POLLS - 1) * GAP + 1;
        run_op(1'b0, 16'h0006, 16'h0000, 1'b1, (POLLS - 1) * GAP + 3, 1'b0, "R7");
        check(rdata == last_rd, "R10", "rdata kept over timeout", rdata, last_rd);
        settle(2 * lat);

        // Acknowledge stuck low and stuck high.
        mode = 1;
        run_op(1'b1, 16'h0008, 16'hC0DE, 1'b1, (POLLS - 1) * GAP + 3, 1'b0, "R7");
        mode = 2;
        settle(3);
        run_op(1'b0, 16'h0008, 16'h0000, 1'b1, (POLLS - 1) * GAP + 4, 1'b0, "R7");
        mode = 0; lat = 2;
        settle(10);
        check(rdata == last_rd, "R10", "rdata kept over stuck ack", rdata, last_rd);
        run_op(1'b0, 16'h0008, 16'h0000, 1'b0, -1, 1'b0, "R7");

        // Requests held during a busy write and its done cycle.
        run_op(1'b1, 16'h000A, 16'hAAAA, 1'b0, 3 + 6 * wait_len(2), 1'b1, "R8");
        run_op(1'b0, 16'h000A, 16'h0000, 1'b0, -1, 1'b0, "R8");
        run_op(1'b0, 16'h0003, 16'h0000, 1'b0, -1, 1'b0, "R8");
        run_op(1'b0, 16'h0004, 16'h0000, 1'b0, -1, 1'b0, "R4");

        settle(5);
        check(sb.size() == 0, "R9", "all completions seen", sb.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule